// File: doc/BRIEF.md
# If-Then Block Predication Sequencer

This block sits beside an instruction decoder and handles predicated blocks. An if-then instruction brings a base condition and a four-bit pattern. It opens a block that covers the next one to four decoded instructions. Each instruction in the block is a then slot or an else slot. A then slot is predicated on the base condition. An else slot is predicated on the opposite condition, which differs from the base only in its least significant bit. For every decoded instruction the block reports three things: the condition that applies to it, whether it lies inside a block, and whether it executes under the current NZCV flags. An instruction that does not execute must be squashed by the pipeline, so it has no register or flag effect.

The sequencer also enforces two side rules. First, a short-form arithmetic instruction normally writes the flags, but it must not write them while it sits inside a block. Second, a branch is legal inside a block only in the last slot. Malformed if-then instructions are rejected with an error and open no block. An if-then that arrives while a block is still open is also rejected.

Top module: `itb_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `in_block` is 0. In the same period `exec_ok`, `br_err`, `cfg_err` and `sf_flag_we` are 0 whenever no strobe is applied.
- R2: The block length is fixed by the lowest set bit of `it_mask`. That bit at position 3 gives 1 slot, position 2 gives 2, position 1 gives 3 and position 0 gives 4. `in_block` rises in the cycle after an accepted `it_start`. It stays high for exactly that many `ins_valid` instructions and falls in the cycle after the last of them.
- R3: Slot 1 is always a then slot. Slot k (k = 2..4) is an else slot when `it_mask` bit 5-k is 1. A then slot reports the base condition on `slot_cond`, and an else slot reports the base with bit 0 inverted. Outside a block, `slot_cond` is 4'hE (always).
- R4: `flags_nzcv` holds N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. Codes 0 to 13 test, in order: Z, !Z, C, !C, N, !N, V, !V, C&!Z, !C|Z, N==V, N!=V, !Z&(N==V), Z|(N!=V). Code 14 always passes. A valid instruction inside a block has `exec_ok` = 1 only if its slot condition passes.
- R5: A valid instruction outside a block always has `exec_ok` = 1. `exec_ok` is 0 in any cycle without `ins_valid`.
- R6: An `it_start` is rejected with `cfg_err` = 1 in the same cycle, and opens no block, in three cases: the mask is 0, the condition is 4'hF, or the condition is 4'hE with any else slot inside the block length.
- R7: An `it_start` while `in_block` is 1 raises `cfg_err`. It leaves the open block and its slot position unchanged.
- R8: `br_err` is 1 for a valid branch inside a block in any slot but the last. It is 0 for a branch in the last slot and for a branch outside a block.
- R9: `sf_flag_we` is 1 for a valid short-form instruction outside a block. It is 0 for a short-form instruction inside a block.
- R10: Each slot is evaluated against `flags_nzcv` in its own cycle, so a flag change between slots changes the result of the later slots.
- R11: Cycles without `ins_valid` do not advance the slot position of an open block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| it_start | input | 1 | Strobe: an if-then instruction is decoded this cycle |
| it_cond | input | 4 | Base condition code of the if-then |
| it_mask | input | 4 | Then/else pattern with its length terminator |
| ins_valid | input | 1 | Strobe: a predicable instruction is decoded this cycle |
| ins_branch | input | 1 | The instruction is a branch |
| ins_short | input | 1 | The instruction is a short-form flag-setting arithmetic op |
| flags_nzcv | input | 4 | Current condition flags {N,Z,C,V} |
| in_block | output | 1 | An if-then block is open for the current slot |
| slot_cond | output | 4 | Effective condition of the current slot |
| exec_ok | output | 1 | The current instruction executes |
| sf_flag_we | output | 1 | The short-form instruction may write the flags |
| br_err | output | 1 | Branch placed before the last slot |
| cfg_err | output | 1 | The if-then is rejected |

## Verification
`slot_cond`, `exec_ok`, `sf_flag_we`, `br_err` and `cfg_err` are combinational results of the strobes of the same cycle, so they are due zero cycles after the stimulus. `in_block` and the slot position move one clock edge after an accepted `it_start` or a consumed instruction. The bench drives every input just after a rising edge. It compares all outputs at the following falling edge against a bench model of the block state. It then advances that model by the one edge that comes next, so each result is checked in the cycle it belongs to.

// File: rtl/itb_pkg.sv
// Shared constants and types for the if-then block sequencer.
// Assumes the 4-bit condition encoding in which bit 0 inverts the test.
package itb_pkg;
    localparam int COND_W = 4;
    localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;
    localparam logic [COND_W-1:0] COND_NONE   = 4'hF;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;
endpackage

// File: rtl/itb_mask_decode.sv
// Decodes an if-then pattern into a block length and a per-slot else vector.
// Assumes the lowest set bit of the mask is the terminator: position p gives
// SLOTS-p slots, and the bits above it pick else (1) or then (0) for slot 2..
module itb_mask_decode #(
    parameter int SLOTS = 4,
    localparam int IDXW = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] mask,
    output logic             mask_ok,
    output logic [IDXW:0]    blk_len,
    output logic [SLOTS-1:0] else_vec
);
    int lo_pos;

    // Locate the terminator bit (lowest set bit).
    always_comb begin
        lo_pos = SLOTS;
        for (int p = SLOTS - 1; p >= 0; p--) begin
            if (mask[p]) lo_pos = p;
        end
    end

    assign mask_ok = |mask;
    assign blk_len = mask_ok ? (IDXW+1)'(SLOTS - lo_pos) : '0;

    // Slot k (zero-based) reads mask bit SLOTS-k when it lies inside the block.
    always_comb begin
        else_vec = '0;
        for (int k = 1; k < SLOTS; k++) begin
            if (k < int'(blk_len)) else_vec[k] = mask[SLOTS-k];
        end
    end
endmodule

// File: rtl/itb_cond_eval.sv
// Evaluates a 4-bit condition code against the NZCV flags.
// Assumes bits 3:1 select the test and bit 0 inverts it, except for the
// always group, which passes for both values of bit 0.
module itb_cond_eval
    import itb_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  nzcv_t             flags,
    output logic              pass
);
    logic raw;

    // Base test chosen by the upper three bits.
    always_comb begin
        unique case (cond[3:1])
            3'd0: raw = flags.z;
            3'd1: raw = flags.c;
            3'd2: raw = flags.n;
            3'd3: raw = flags.v;
            3'd4: raw = flags.c & ~flags.z;
            3'd5: raw = (flags.n == flags.v);
            3'd6: raw = ~flags.z & (flags.n == flags.v);
            default: raw = 1'b1;
        endcase
    end

    // Apply the inversion bit outside the always group.
    assign pass = (cond[3:1] == 3'd7) ? 1'b1 : (raw ^ cond[0]);
endmodule

// File: rtl/itb_slot_state.sv
// Holds the open-block state: base condition, else pattern, length, position.
// Assumes open and step are never both acted on: open takes priority.
module itb_slot_state
    import itb_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int IDXW = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open,
    input  logic [COND_W-1:0] base_in,
    input  logic [SLOTS-1:0]  else_in,
    input  logic [IDXW:0]     len_in,
    input  logic              step,
    output logic              active,
    output logic [COND_W-1:0] base,
    output logic              cur_else,
    output logic              last
);
    logic [SLOTS-1:0] else_q;
    logic [IDXW:0]    len_q;
    logic [IDXW-1:0]  idx_q;

    // Load a new block, or advance/close on each consumed instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            base   <= '0;
            else_q <= '0;
            len_q  <= '0;
            idx_q  <= '0;
        end else if (open) begin
            active <= 1'b1;
            base   <= base_in;
            else_q <= else_in;
            len_q  <= len_in;
            idx_q  <= '0;
        end else if (step && active) begin
            if (last) active <= 1'b0;
            else      idx_q  <= idx_q + 1'b1;
        end
    end

    assign cur_else = else_q[idx_q];
    assign last     = (({1'b0, idx_q} + 1'b1) == len_q);
endmodule

// File: rtl/itb_seq.sv
// Top of the if-then block sequencer. It accepts or rejects if-then
// instructions and predicates the following slots. Per instruction it drives
// the condition, execute, flag-write and branch-placement results.
// Assumes it_start and ins_valid are not asserted in the same cycle.
module itb_seq
    import itb_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int IDXW = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              it_start,
    input  logic [COND_W-1:0] it_cond,
    input  logic [SLOTS-1:0]  it_mask,
    input  logic              ins_valid,
    input  logic              ins_branch,
    input  logic              ins_short,
    input  logic [3:0]        flags_nzcv,
    output logic              in_block,
    output logic [COND_W-1:0] slot_cond,
    output logic              exec_ok,
    output logic              sf_flag_we,
    output logic              br_err,
    output logic              cfg_err
);
    logic              mask_ok;
    logic [IDXW:0]     dec_len;
    logic [SLOTS-1:0]  dec_else;
    logic              accept;
    logic              step;
    logic              active;
    logic [COND_W-1:0] base;
    logic              cur_else;
    logic              last;
    logic              pass;
    nzcv_t             flags;

    itb_mask_decode #(.SLOTS(SLOTS)) u_dec (
        .mask     (it_mask),
        .mask_ok  (mask_ok),
        .blk_len  (dec_len),
        .else_vec (dec_else)
    );

    // Accept only well-formed if-then instructions outside an open block.
    always_comb begin
        accept = it_start & ~active & mask_ok & (it_cond != COND_NONE)
               & ~((it_cond == COND_ALWAYS) & (|dec_else));
    end

    assign cfg_err = it_start & ~accept;
    assign step    = ins_valid & ~it_start;

    itb_slot_state #(.SLOTS(SLOTS)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .open     (accept),
        .base_in  (it_cond),
        .else_in  (dec_else),
        .len_in   (dec_len),
        .step     (step),
        .active   (active),
        .base     (base),
        .cur_else (cur_else),
        .last     (last)
    );

    // Effective condition: base or its opposite inside a block, else always.
    always_comb begin
        if (active) slot_cond = {base[COND_W-1:1], base[0] ^ cur_else};
        else        slot_cond = COND_ALWAYS;
    end

    assign flags = nzcv_t'(flags_nzcv);

    itb_cond_eval u_eval (
        .cond  (slot_cond),
        .flags (flags),
        .pass  (pass)
    );

    assign in_block   = active;
    assign exec_ok    = ins_valid & pass;
    assign br_err     = ins_valid & active & ins_branch & ~last;
    assign sf_flag_we = ins_valid & ins_short & ~active;
endmodule

// File: rtl/itb_seq_chk.sv
// Property checker for itb_seq, attached to every instance by bind.
// Assumes synchronous active-low reset; all properties are off during reset.
module itb_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       it_start,
    input logic       ins_valid,
    input logic       ins_branch,
    input logic       ins_short,
    input logic       in_block,
    input logic [3:0] slot_cond,
    input logic       exec_ok,
    input logic       sf_flag_we,
    input logic       br_err,
    input logic       cfg_err
);
    // R2
    blk_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_block) |-> $past(it_start && !cfg_err));
    // R3
    idle_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_block |-> slot_cond == 4'hE);
    // R5
    out_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !in_block) |-> exec_ok);
    // R7
    nested_it_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (it_start && in_block) |-> cfg_err);
    // R7
    nested_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (it_start && in_block && !ins_valid) |=> in_block);
    // R8
    br_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_block || !ins_branch) |-> !br_err);
    // R9
    sf_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_short && in_block) |-> !sf_flag_we);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_block && !ins_valid && !it_start) |=> in_block);
endmodule

bind itb_seq itb_seq_chk u_itb_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .it_start   (it_start),
    .ins_valid  (ins_valid),
    .ins_branch (ins_branch),
    .ins_short  (ins_short),
    .in_block   (in_block),
    .slot_cond  (slot_cond),
    .exec_ok    (exec_ok),
    .sf_flag_we (sf_flag_we),
    .br_err     (br_err),
    .cfg_err    (cfg_err)
);

// File: tb/test_itb_seq.sv
// Self-checking bench for itb_seq: directed corner cases plus seeded random.
module test_itb_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       it_start = 1'b0;
    logic [3:0] it_cond = 4'h0;
    logic [3:0] it_mask = 4'h0;
    logic       ins_valid = 1'b0;
    logic       ins_branch = 1'b0;
    logic       ins_short = 1'b0;
    logic [3:0] flags_nzcv = 4'h0;
    logic       in_block;
    logic [3:0] slot_cond;
    logic       exec_ok;
    logic       sf_flag_we;
    logic       br_err;
    logic       cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model of the block state.
    bit       m_act = 0;
    bit [3:0] m_base = 0;
    int       m_len = 0;
    int       m_idx = 0;
    bit [3:0] m_else = 0;

    always #10 clk = ~clk;

    itb_seq i_itb_seq (
        .clk(clk), .rst_n(rst_n), .it_start(it_start), .it_cond(it_cond),
        .it_mask(it_mask), .ins_valid(ins_valid), .ins_branch(ins_branch),
        .ins_short(ins_short), .flags_nzcv(flags_nzcv), .in_block(in_block),
        .slot_cond(slot_cond), .exec_ok(exec_ok), .sf_flag_we(sf_flag_we),
        .br_err(br_err), .cfg_err(cfg_err)
    );

    function automatic bit cond_true(input bit [3:0] c, input bit [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    function automatic int len_of(input bit [3:0] m);
        if (m[0]) return 4;
        if (m[1]) return 3;
        if (m[2]) return 2;
        if (m[3]) return 1;
        return 0;
    endfunction

    function automatic bit [3:0] else_of(input bit [3:0] m);
        bit [3:0] e = 0;
        int l = len_of(m);
        for (int k = 1; k < 4; k++) if (k < l) e[k] = m[4-k];
        return e;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive after the rising edge, check at the falling edge, update model.
    task automatic step(input bit it, input bit [3:0] c, input bit [3:0] m,
                        input bit v, input bit br, input bit sh, input bit [3:0] fl,
                        input string tag);
        bit e_cfg, e_exec, e_br, e_sf, last;
        bit [3:0] e_cond;
        @(posedge clk); #1;
        it_start = it; it_cond = c; it_mask = m; ins_valid = v;
        ins_branch = br; ins_short = sh; flags_nzcv = fl;
        @(negedge clk);
        last   = m_act && (m_idx == m_len - 1);
        e_cfg  = it && (m_act || m == 0 || c == 4'hF || (c == 4'hE && else_of(m) != 0));
        e_cond = m_act ? (m_base ^ {3'b0, m_else[m_idx]}) : 4'hE;
        e_exec = v && cond_true(e_cond, fl);
        e_br   = v && m_act && br && !last;
        e_sf   = v && sh && !m_act;
        chk(tag == "" ? "R2" : tag, "in_block", in_block, m_act);
        chk(tag == "" ? "R3" : tag, "slot_cond", slot_cond, e_cond);
        chk(tag == "" ? (m_act ? "R4" : "R5") : tag, "exec_ok", exec_ok, e_exec);
        chk(tag == "" ? (m_act ? "R7" : "R6") : tag, "cfg_err", cfg_err, e_cfg);
        chk(tag == "" ? "R8" : tag, "br_err", br_err, e_br);
        chk(tag == "" ? "R9" : tag, "sf_flag_we", sf_flag_we, e_sf);
        if (it && !e_cfg) begin
            m_act = 1; m_base = c; m_len = len_of(m); m_idx = 0; m_else = else_of(m);
        end else if (v && !it && m_act) begin
            if (last) m_act = 0;
            else      m_idx++;
        end
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 4'h0, tag);
    endtask

    task automatic ins(input bit br, input bit sh, input bit [3:0] fl, input string tag);
        step(0, 0, 0, 1, br, sh, fl, tag);
    endtask

    task automatic itx(input bit [3:0] c, input bit [3:0] m, input string tag);
        step(1, c, m, 0, 0, 0, 4'h0, tag);
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1", "in_block", in_block, 0);
        chk("R1", "exec_ok", exec_ok, 0);
        chk("R1", "cfg_err", cfg_err, 0);
        chk("R1", "br_err", br_err, 0);
        chk("R1", "sf_flag_we", sf_flag_we, 0);
        rst_n = 1'b1;
        idle("R1");

        // R3/R4: then-else on carry clear; flags C=0
        itx(4'd3, 4'b1100, "");
        ins(0, 0, 4'b0000, "R3");
        ins(0, 0, 4'b0000, "R4");
        idle("R2");

        // R6: malformed if-then instructions
        itx(4'hE, 4'b1100, "R6");
        itx(4'h2, 4'b0000, "R6");
        itx(4'hF, 4'b1000, "R6");
        ins(0, 0, 4'h0, "R6");
        // R6: always with then-only slots is accepted
        itx(4'hE, 4'b0001, "R6");
        repeat (4) ins(0, 0, 4'h5, "R6");

        // R7: nested if-then rejected, position kept
        itx(4'd0, 4'b1010, "");
        ins(0, 0, 4'b0100, "R7");
        itx(4'd1, 4'b1000, "R7");
        ins(0, 0, 4'b0100, "R7");
        ins(0, 0, 4'b0100, "R7");
        idle("R7");

        // R8: branch placement
        itx(4'd10, 4'b0110, "");
        ins(1, 0, 4'h0, "R8");
        ins(0, 0, 4'h0, "R8");
        ins(1, 0, 4'h0, "R8");
        ins(1, 0, 4'h0, "R8");

        // R9: short forms outside and inside
        ins(0, 1, 4'h0, "R9");
        itx(4'd12, 4'b1000, "");
        ins(0, 1, 4'h0, "R9");
        ins(0, 1, 4'h0, "R9");

        // R10: flags change between slots of an equal-then-then block
        itx(4'd0, 4'b0100, "");
        ins(0, 0, 4'b0100, "R10");
        ins(0, 0, 4'b0000, "R10");

        // R11: idle gaps do not advance the block
        itx(4'd8, 4'b1011, "");
        ins(0, 0, 4'b0010, "R11");
        repeat (3) idle("R11");
        ins(0, 0, 4'b0010, "R11");
        idle("R11");
        ins(0, 0, 4'b0010, "R11");
        ins(0, 0, 4'b0010, "R11");
        idle("R11");

        // Random traffic
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 9);
            if (r < 2)
                step(1, 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                     0, 0, 0, 4'($urandom), "");
            else if (r < 8)
                step(0, 0, 0, 1, 1'($urandom), 1'($urandom), 4'($urandom), "");
            else
                step(0, 0, 0, 0, 1'($urandom), 1'($urandom), 4'($urandom), "");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule